// File: doc/BRIEF.md
# Colour-Space Matrix with Round, Select and Clamp

This block turns one pixel per clock of offset-free luma and chroma (an unsigned 10-bit Y' and signed 10-bit Cb' and Cr') into full-range 10-bit R, G and B. Each colour output is the sum of three signed products: a row of a programmable 3x3 coefficient matrix times the three input components. Coefficients are signed 13-bit fixed point with 10 fractional bits. At reset the matrix expands video-range input to full-range output, with gains of about 1.1678 on luma and chroma terms of 1.6007, -0.3929, -0.81532 and 2.0232.

Each output channel then passes through its own round, select and limit stage. A rounding constant is added to the full-precision sum. The sum is shifted right arithmetically by a programmable select count, and the result is clamped between a lower and an upper limit. The outputs sit in the low ten bits of 13-bit buses, and a valid flag follows them.

Software writes the settings over a small address/data port. A write goes into a shadow copy. A two-state controller moves the shadow into the working set only when no pixel is entering or in flight, so a single pixel never mixes old and new settings.

Top module: `ycc2rgb_matrix`

## Requirements
- R1: After reset the nine matrix entries at addresses 0..8 are 0x04AB, 0x0000, 0x0667, 0x04AB, 0x1E6E, 0x1CBE, 0x04AB, 0x0817, 0x0000. Every channel has rounding constant 0x200, select 10, upper limit 1023 and lower limit 0. out_valid is low and all outputs are zero.
- R2: The matrix is row-major. Address 3*c+k holds the weight of input k (0 = Y', 1 = Cb', 2 = Cr') for output c (0 = R, 1 = G, 2 = B). Each entry is a two's-complement 13-bit value, and Y' is treated as unsigned while Cb' and Cr' are treated as signed. Output c is the sum of the three products.
- R3: The channel's rounding constant is added to the full-precision sum. The result is then shifted right arithmetically (floor) by the channel's select count.
- R4: The shifted value is limited to the channel's upper limit and then raised to its lower limit. With the reset settings, every output lies in 0..1023.
- R5: out_valid equals in_valid from exactly three clocks earlier. While out_valid is low, all three outputs are zero.
- R6: Bits 12:10 of r_out, g_out and b_out are always zero.
- R7: A write reaches the working settings only at a clock edge where in_valid is low and neither of the first two pipeline stages holds a pixel. A continuous stream keeps the old settings until its first gap of that kind.
- R8: Address map: 0..8 are matrix entries. Address 16+4*c+f holds field f of channel c (c: 0 = R, 1 = G, 2 = B; f: 0 = rounding constant in 13 bits, 1 = select in data bits 3:0, 2 = upper limit in bits 9:0, 3 = lower limit in bits 9:0). Writes to 9..15 and 28..31 change nothing.
- R9: The controller has two states, CFG_CLEAN and CFG_PENDING. A write to a mapped address moves it to CFG_PENDING. It returns to CFG_CLEAN, copying shadow to working set, on an edge with no pixel entering or in stages one and two and no mapped write. A mapped write on that edge still triggers the copy but keeps the controller in CFG_PENDING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present on the component inputs |
| y_in | input | 10 | Offset-free luma, unsigned |
| cb_in | input | 10 | Offset-free blue difference, two's complement |
| cr_in | input | 10 | Offset-free red difference, two's complement |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address |
| cfg_data | input | 13 | Configuration write data |
| out_valid | output | 1 | Outputs hold a converted pixel |
| r_out | output | 13 | Red in bits 9:0, upper bits zero |
| g_out | output | 13 | Green in bits 9:0, upper bits zero |
| b_out | output | 13 | Blue in bits 9:0, upper bits zero |

## Verification
On every cycle the assertions check:
- the three-cycle valid delay and the zero outputs between pixels;
- the zero padding bits;
- that each valid output lies within the working limits of its channel;
- that the working set never changes while a pixel is entering or in flight;
- the controller's move to CFG_PENDING on mapped writes, and that ignored addresses leave it alone.

Only the bench's scenarios can show the arithmetic itself: the products and sign handling, rounding and floor shifting under changed select counts, inverted limits, and the exact cycle at which a deferred write first shows up in the pixel stream.

// File: rtl/cmx_pkg.sv
`timescale 1ns/1ps
package cmx_pkg;
    localparam int PIX_W    = 10;
    localparam int COEF_W   = 13;
    localparam int SEL_W    = 4;
    localparam int ADDR_W   = 5;
    localparam int BUS_W    = 13;
    localparam int NCH      = 3;
    localparam int NCOEF    = NCH * NCH;
    localparam int RSL_BASE = 16;
    localparam int RSL_SPAN = 4;

    typedef enum logic [0:0] {
        CFG_CLEAN   = 1'b0,
        CFG_PENDING = 1'b1
    } cfg_state_e;

    typedef struct packed {
        logic [COEF_W-1:0] rnd;
        logic [SEL_W-1:0]  sel;
        logic [PIX_W-1:0]  hi;
        logic [PIX_W-1:0]  lo;
    } rsl_t;

    function automatic logic [COEF_W-1:0] coef_default(input int idx);
        logic [COEF_W-1:0] v;
        case (idx)
            0, 3, 6: v = 13'h04AB;
            2:       v = 13'h0667;
            4:       v = 13'h1E6E;
            5:       v = 13'h1CBE;
            7:       v = 13'h0817;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic rsl_t rsl_default();
        rsl_t r;
        r.rnd = COEF_W'(1 << 9);
        r.sel = SEL_W'(10);
        r.hi  = PIX_W'(1023);
        r.lo  = '0;
        return r;
    endfunction
endpackage

// File: rtl/cmx_cfg_regs.sv
`timescale 1ns/1ps
module cmx_cfg_regs
    import cmx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = COEF_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [AW-1:0]               cfg_addr,
    input  logic [CW-1:0]               cfg_data,
    input  logic                        busy,
    output logic [NCOEF-1:0][CW-1:0]    coef_act,
    output rsl_t [NCH-1:0]              rsl_act,
    output cfg_state_e                  state
);
    localparam int RSL_END = RSL_BASE + RSL_SPAN * NCH;

    logic [NCOEF-1:0][CW-1:0] coef_sh;
    rsl_t [NCH-1:0]           rsl_sh;
    cfg_state_e               state_q, state_d;
    logic                     coef_hit, rsl_hit, map_hit, commit;

    assign coef_hit = cfg_addr < AW'(NCOEF);
    assign rsl_hit  = (cfg_addr >= AW'(RSL_BASE)) && (cfg_addr < AW'(RSL_END));
    assign map_hit  = cfg_we && (coef_hit || rsl_hit);

    // shadow matrix entries
    for (genvar i = 0; i < NCOEF; i++) begin : g_coef
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                coef_sh[i] <= coef_default(i);
            else if (cfg_we && cfg_addr == AW'(i))
                coef_sh[i] <= cfg_data;
        end
    end

    // shadow round/select/limit sets, one per output channel
    for (genvar c = 0; c < NCH; c++) begin : g_rsl
        localparam int BASE = RSL_BASE + RSL_SPAN * c;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rsl_sh[c] <= rsl_default();
            end else if (cfg_we) begin
                if (cfg_addr == AW'(BASE + 0)) rsl_sh[c].rnd <= cfg_data;
                if (cfg_addr == AW'(BASE + 1)) rsl_sh[c].sel <= cfg_data[SEL_W-1:0];
                if (cfg_addr == AW'(BASE + 2)) rsl_sh[c].hi  <= cfg_data[PIX_W-1:0];
                if (cfg_addr == AW'(BASE + 3)) rsl_sh[c].lo  <= cfg_data[PIX_W-1:0];
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_CLEAN;
        else        state_q <= state_d;
    end

    // next state and commit strobe
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            CFG_CLEAN: begin
                if (map_hit) state_d = CFG_PENDING;
            end
            CFG_PENDING: begin
                if (!busy) begin
                    commit = 1'b1;
                    if (!map_hit) state_d = CFG_CLEAN;
                end
            end
        endcase
    end

    // working copy, moved from the shadow only in a pipeline gap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCOEF; i++) coef_act[i] <= coef_default(i);
            for (int c = 0; c < NCH; c++)   rsl_act[c]  <= rsl_default();
        end else if (commit) begin
            coef_act <= coef_sh;
            rsl_act  <= rsl_sh;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/cmx_channel.sv
`timescale 1ns/1ps
module cmx_channel
    import cmx_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int CW = COEF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PW-1:0]            y_in,
    input  logic [PW-1:0]            cb_in,
    input  logic [PW-1:0]            cr_in,
    input  logic [NCH-1:0][CW-1:0]   row,
    input  rsl_t                     rsl,
    input  logic                     valid_b,
    output logic [PW-1:0]            res
);
    localparam int OP_W   = PW + 1;
    localparam int PROD_W = CW + OP_W;
    localparam int ACC_W  = PROD_W + 3;

    logic signed [OP_W-1:0]   op     [NCH];
    logic signed [PROD_W-1:0] prod_q [NCH];
    logic signed [ACC_W-1:0]  sum_c, acc_q, shf_c, lim_c, hi_c, lo_c;

    assign op[0] = $signed({1'b0, y_in});
    assign op[1] = $signed({cb_in[PW-1], cb_in});
    assign op[2] = $signed({cr_in[PW-1], cr_in});

    // stage A: three full-precision products
    for (genvar k = 0; k < NCH; k++) begin : g_mul
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_q[k] <= '0;
            else        prod_q[k] <= PROD_W'($signed(row[k])) * PROD_W'(op[k]);
        end
    end

    // stage B: sum plus rounding constant
    always_comb begin
        sum_c = ACC_W'($signed({1'b0, rsl.rnd}));
        for (int k = 0; k < NCH; k++) sum_c = sum_c + ACC_W'(prod_q[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum_c;
    end

    // stage C: select by arithmetic shift, upper then lower limit
    assign hi_c  = ACC_W'($signed({1'b0, rsl.hi}));
    assign lo_c  = ACC_W'($signed({1'b0, rsl.lo}));
    always_comb begin
        shf_c = acc_q >>> rsl.sel;
        lim_c = (shf_c > hi_c) ? hi_c : shf_c;
        if (lim_c < lo_c) lim_c = lo_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       res <= '0;
        else if (valid_b) res <= lim_c[PW-1:0];
        else              res <= '0;
    end
endmodule

// File: rtl/ycc2rgb_matrix.sv
`timescale 1ns/1ps
module ycc2rgb_matrix
    import cmx_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int CW = COEF_W,
    parameter int AW = ADDR_W,
    parameter int BW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [PW-1:0] y_in,
    input  logic [PW-1:0] cb_in,
    input  logic [PW-1:0] cr_in,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_data,
    output logic          out_valid,
    output logic [BW-1:0] r_out,
    output logic [BW-1:0] g_out,
    output logic [BW-1:0] b_out
);
    logic                     v_a, v_b, v_c, busy;
    logic [NCOEF-1:0][CW-1:0] coef_act;
    rsl_t [NCH-1:0]           rsl_act;
    cfg_state_e               cfg_state;
    logic [PW-1:0]            res [NCH];

    assign busy = in_valid | v_a | v_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_a <= 1'b0;
            v_b <= 1'b0;
            v_c <= 1'b0;
        end else begin
            v_a <= in_valid;
            v_b <= v_a;
            v_c <= v_b;
        end
    end

    cmx_cfg_regs #(.AW(AW), .CW(CW)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .busy     (busy),
        .coef_act (coef_act),
        .rsl_act  (rsl_act),
        .state    (cfg_state)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cmx_channel #(.PW(PW), .CW(CW)) i_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .y_in    (y_in),
            .cb_in   (cb_in),
            .cr_in   (cr_in),
            .row     (coef_act[NCH*c +: NCH]),
            .rsl     (rsl_act[c]),
            .valid_b (v_b),
            .res     (res[c])
        );
    end

    assign out_valid = v_c;
    assign r_out     = BW'(res[0]);
    assign g_out     = BW'(res[1]);
    assign b_out     = BW'(res[2]);
endmodule

// File: rtl/cmx_checker.sv
`timescale 1ns/1ps
module cmx_checker
    import cmx_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          cfg_we,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic                          out_valid,
    input  logic [BUS_W-1:0]              r_out,
    input  logic [BUS_W-1:0]              g_out,
    input  logic [BUS_W-1:0]              b_out,
    input  logic [NCOEF-1:0][COEF_W-1:0]  coef_act,
    input  rsl_t [NCH-1:0]                rsl_act,
    input  cfg_state_e                    cfg_state
);
    logic [1:0] cyc_q;
    logic       mapped, unmapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    assign mapped   = cfg_addr < ADDR_W'(NCOEF) ||
                      (cfg_addr >= ADDR_W'(RSL_BASE) && cfg_addr < ADDR_W'(RSL_BASE + RSL_SPAN * NCH));
    assign unmapped = !mapped;

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));                    // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (r_out == '0 && g_out == '0 && b_out == '0));               // R5
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (r_out[BUS_W-1:PIX_W] == '0 && g_out[BUS_W-1:PIX_W] == '0
         && b_out[BUS_W-1:PIX_W] == '0));                                           // R6
    AST_LIMIT_R: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rsl_act[0].lo <= rsl_act[0].hi) |->
        (r_out[PIX_W-1:0] >= rsl_act[0].lo && r_out[PIX_W-1:0] <= rsl_act[0].hi)); // R4
    AST_LIMIT_G: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rsl_act[1].lo <= rsl_act[1].hi) |->
        (g_out[PIX_W-1:0] >= rsl_act[1].lo && g_out[PIX_W-1:0] <= rsl_act[1].hi)); // R4
    AST_LIMIT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rsl_act[2].lo <= rsl_act[2].hi) |->
        (b_out[PIX_W-1:0] >= rsl_act[2].lo && b_out[PIX_W-1:0] <= rsl_act[2].hi)); // R4
    AST_NO_MIXED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($stable(coef_act) && $stable(rsl_act))
                 ##1 ($stable(coef_act) && $stable(rsl_act))
                 ##1 ($stable(coef_act) && $stable(rsl_act)));                     // R7
    AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && mapped) |=> (cfg_state == CFG_PENDING));                        // R9
    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_state == CFG_CLEAN && (!cfg_we || unmapped)) |=> (cfg_state == CFG_CLEAN)); // R8
endmodule

bind ycc2rgb_matrix cmx_checker i_cmx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .out_valid (out_valid),
    .r_out     (r_out),
    .g_out     (g_out),
    .b_out     (b_out),
    .coef_act  (coef_act),
    .rsl_act   (rsl_act),
    .cfg_state (cfg_state)
);

// File: tb/test_ycc2rgb_matrix.sv
`timescale 1ns/1ps
module test_ycc2rgb_matrix;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [9:0]  y_in = '0, cb_in = '0, cr_in = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [12:0] cfg_data = '0;
    logic        out_valid;
    logic [12:0] r_out, g_out, b_out;

    int total = 0, bad = 0;
    bit done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    ycc2rgb_matrix i_ycc2rgb_matrix (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .out_valid(out_valid), .r_out(r_out), .g_out(g_out), .b_out(b_out)
    );

    // behavioural reference
    int  m_coef_sh[9], m_coef_act[9];
    int  m_rnd_sh[3], m_sel_sh[3], m_hi_sh[3], m_lo_sh[3];
    int  m_rnd[3], m_sel[3], m_hi[3], m_lo[3];
    bit  m_pend, ivd1, ivd2;
    bit  pv[3];
    int  pres[3][3];

    function automatic int sx13(input int v);
        return (v >= 4096) ? v - 8192 : v;
    endfunction

    task automatic model_reset();
        int defs[9] = '{'h04AB, 0, 'h0667, 'h04AB, 'h1E6E, 'h1CBE, 'h04AB, 'h0817, 0};
        for (int i = 0; i < 9; i++) begin m_coef_sh[i] = sx13(defs[i]); m_coef_act[i] = m_coef_sh[i]; end
        for (int c = 0; c < 3; c++) begin
            m_rnd_sh[c] = 512; m_sel_sh[c] = 10; m_hi_sh[c] = 1023; m_lo_sh[c] = 0;
            m_rnd[c] = 512; m_sel[c] = 10; m_hi[c] = 1023; m_lo[c] = 0;
        end
        for (int s = 0; s < 3; s++) begin pv[s] = 0; pres[s] = '{0, 0, 0}; end
        m_pend = 0; ivd1 = 0; ivd2 = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit busy, commit, hit;
            int nr[3];
            int a;
            busy   = in_valid || ivd1 || ivd2;
            commit = m_pend && !busy;
            for (int c = 0; c < 3; c++) begin
                longint acc;
                acc = longint'(m_coef_act[3*c]) * int'(y_in)
                    + longint'(m_coef_act[3*c+1]) * int'($signed(cb_in))
                    + longint'(m_coef_act[3*c+2]) * int'($signed(cr_in))
                    + m_rnd[c];
                acc = acc >>> m_sel[c];
                if (acc > m_hi[c]) acc = m_hi[c];
                if (acc < m_lo[c]) acc = m_lo[c];
                nr[c] = in_valid ? int'(acc) : 0;
            end
            pv[2] = pv[1]; pres[2] = pres[1];
            pv[1] = pv[0]; pres[1] = pres[0];
            pv[0] = in_valid; pres[0] = nr;
            if (commit) begin
                m_coef_act = m_coef_sh;
                m_rnd = m_rnd_sh; m_sel = m_sel_sh; m_hi = m_hi_sh; m_lo = m_lo_sh;
            end
            a = int'(cfg_addr);
            hit = 0;
            if (cfg_we) begin
                if (a < 9) begin m_coef_sh[a] = sx13(int'(cfg_data)); hit = 1; end
                else if (a >= 16 && a < 28) begin
                    int c, f;
                    c = (a - 16) / 4; f = (a - 16) % 4;
                    hit = 1;
                    case (f)
                        0: m_rnd_sh[c] = int'(cfg_data);
                        1: m_sel_sh[c] = int'(cfg_data[3:0]);
                        2: m_hi_sh[c]  = int'(cfg_data[9:0]);
                        default: m_lo_sh[c] = int'(cfg_data[9:0]);
                    endcase
                end
            end
            if (hit) m_pend = 1;
            else if (commit) m_pend = 0;
            ivd2 = ivd1; ivd1 = in_valid;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (out_valid !== pv[2] || r_out !== 13'(pres[2][0]) ||
                g_out !== 13'(pres[2][1]) || b_out !== 13'(pres[2][2])) begin
                bad++;
                $display("FAIL %s t=%0t actual v=%0b r=%0d g=%0d b=%0d expected v=%0b r=%0d g=%0d b=%0d",
                         cur_req, $time, out_valid, r_out, g_out, b_out,
                         pv[2], pres[2][0], pres[2][1], pres[2][2]);
            end
        end
    end

    task automatic check(input string req, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input bit iv, input int y, input int cb, input int cr,
                       input bit we, input int addr, input int data);
        @(negedge clk);
        in_valid = iv; y_in = 10'(y); cb_in = 10'(cb); cr_in = 10'(cr);
        cfg_we = we; cfg_addr = 5'(addr); cfg_data = 13'(data);
    endtask

    task automatic px(input int y, input int cb, input int cr);
        cyc(1, y, cb, cr, 0, 0, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input int addr, input int data);
        cyc(0, 0, 0, 0, 1, addr, data);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", out_valid == 0, out_valid, 0);
        check("R1 outputs zero after reset", (r_out | g_out | b_out) == 0, r_out | g_out | b_out, 0);
        px(0, 0, 0); px(876, 0, 0); px(438, 0, 0);
        idle(4);

        // R2: default matrix under several colours
        cur_req = "R2";
        px(876, 0, 448); px(876, 448, 0); px(0, -448, 448); px(438, -448, -448);
        px(200, 100, -50); px(65, -3, 7); px(876, -448, -448);
        idle(4);
        // identity matrix
        for (int i = 0; i < 9; i++) wr(i, (i % 4 == 0) ? 1024 : 0);
        idle(3);
        px(500, 300, -200); px(1, -1, 1); px(876, 448, 448);
        idle(4);

        // R3: rounding constant and select count
        cur_req = "R3";
        wr(20, 0); wr(21, 9); wr(24, 13'h400); wr(25, 11);
        idle(3);
        px(300, 301, 301); px(700, 511, 255); px(5, 3, 3); px(1023, -512, 7);
        idle(4);
        wr(20, 13'h200); wr(21, 10); wr(24, 13'h200); wr(25, 10);
        for (int i = 0; i < 9; i++) wr(i, (i == 0 || i == 3 || i == 6) ? 13'h04AB :
                                          (i == 2) ? 13'h0667 : (i == 4) ? 13'h1E6E :
                                          (i == 5) ? 13'h1CBE : (i == 7) ? 13'h0817 : 0);
        idle(3);

        // R4: clamping, default and programmed limits
        cur_req = "R4";
        px(876, 448, 448); px(0, -448, -448); px(0, 448, -448);
        idle(1);
        wr(18, 800); wr(19, 100); wr(26, 200); wr(27, 600);
        idle(3);
        px(876, 448, 448); px(0, -448, -448); px(438, 0, 0); px(300, 40, -40);
        idle(4);
        wr(18, 1023); wr(19, 0); wr(26, 1023); wr(27, 0);
        idle(3);

        // R5 / R6: gapped valid patterns
        cur_req = "R5";
        for (int i = 0; i < 40; i++) begin
            if (i % 3 == 0) idle(1 + i % 2);
            px(i * 23 % 877, (i * 37 % 897) - 448, 448 - (i * 51 % 897));
        end
        idle(4);
        cur_req = "R6";
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R6 upper bits zero", (r_out[12:10] | g_out[12:10] | b_out[12:10]) == 0,
                  r_out[12:10] | g_out[12:10] | b_out[12:10], 0);
            in_valid = 1; y_in = 10'(876 - i); cb_in = 10'(448 - i); cr_in = 10'(448 - 2 * i);
        end
        idle(4);

        // R7 / R9: writes during a continuous stream stay pending
        cur_req = "R7";
        px(400, 100, 100);
        cyc(1, 400, 100, 100, 1, 2, 0);
        cyc(1, 400, 100, 100, 1, 17, 11);
        for (int i = 0; i < 10; i++) px(400 + i, 100, 100);
        cur_req = "R9";
        cyc(0, 0, 0, 0, 0, 0, 0);
        px(400, 100, 100);
        idle(1);
        cyc(0, 0, 0, 0, 1, 8, 13'h0400);
        cyc(0, 0, 0, 0, 1, 2, 13'h0667);
        px(400, 100, 100); px(600, -50, 200);
        idle(1);
        wr(17, 10);
        idle(3);
        px(400, 100, 100); px(600, -50, 200);
        idle(4);
        wr(8, 0);
        idle(3);

        // R8: unmapped addresses
        cur_req = "R8";
        wr(9, 13'h1FFF); wr(15, 13'h0123); wr(28, 5); wr(31, 13'h1000);
        idle(3);
        px(876, 448, 448); px(300, -100, 50);
        idle(4);

        // mixed random traffic against the reference
        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel == 0)
                cyc(0, 0, 0, 0, 1, int'($urandom_range(0, 8)),
                    int'($urandom_range(0, 8191)));
            else if (sel == 1) idle(1);
            else px(int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)) - 512,
                    int'($urandom_range(0, 1023)) - 512);
        end
        idle(6);
        finish_run();
    end
endmodule